// File: doc/BRIEF.md
# Peer-Clocked Serial Byte Link

This block is the host end of a byte-at-a-time serial link to a power-management controller. The controller owns the shift clock. The host owns an active-low request line and watches an active-low acknowledge line. One four-phase handshake frames each byte. The host asks for a transfer with a valid/ready pair that carries a direction bit and, for a send, the byte to send. The link then shifts the byte out, or collects one in, on the peer's clock edges. It closes the handshake, then reports completion with a one-cycle done pulse. A received byte is presented on `rx_byte`.

The start interface follows valid/ready rules with no queue. `start_ready` is high only while the link is idle. A request is taken in the cycle where `start_valid` and `start_ready` are both high. There is no back-pressure beyond that: a caller that holds `start_valid` while busy is not served until the link is idle again, and nothing offered during a transfer is stored. The shift clock, serial input and acknowledge all cross into the system clock through two-flop synchronisers. The link shifts on each synchronised rising edge of the shift clock, most significant bit first.

Top module: `pm_byte_link`

## Requirements
- R1: Out of reset, `req_n` is 1, `sdout` is 1, `busy` is 0, `done` is 0, `start_ready` is 1 and `rx_byte` is 0x00.
- R2: A start is accepted only in a cycle with `start_valid`=1 and `start_ready`=1. `start_ready` is 1 only while idle. `busy` is 1 from the cycle after acceptance through the done cycle.
- R3: While a transfer is in progress, a start request has no effect: no second transfer follows, and neither the result nor the outgoing data changes.
- R4: After acceptance, `req_n` goes to 0 and stays 0 until the synchronised `ack_n` is seen low. Only then does `req_n` return to 1, and it stays 1 while idle.
- R5: `done` is a pulse one system clock wide. It appears only after `ack_n` has returned high following the release of `req_n`, and never while `ack_n` is still low.
- R6: With `start_dir`=0 (send), `sdout` presents `start_byte` most significant bit first. Each bit is held until the next synchronised rising edge of `sclk`. Whenever no send is in progress, `sdout` is 1.
- R7: With `start_dir`=1 (receive), the shifter is cleared at acceptance. `sdin` is sampled at each synchronised rising edge of `sclk`, and the first bit is the most significant. At done, the 8 collected bits appear on `rx_byte`.
- R8: Only the first 8 rising `sclk` edges of a transfer shift data. Later edges are ignored for both the received value and the sent bits.
- R9: `rx_byte` changes only on the done cycle of a receive. It holds its value through send transfers and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Transfer request valid |
| start_ready | output | 1 | Link idle, request can be taken |
| start_dir | input | 1 | 0 = send `start_byte`, 1 = receive |
| start_byte | input | 8 | Byte to send |
| req_n | output | 1 | Active-low transfer request to peer |
| ack_n | input | 1 | Active-low acknowledge from peer (asynchronous) |
| sclk | input | 1 | Peer-driven shift clock (asynchronous) |
| sdin | input | 1 | Serial data from peer |
| sdout | output | 1 | Serial data to peer |
| rx_byte | output | 8 | Last received byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
A handshake state machine stuck in the wrong state shows at the ports as `req_n` held at the wrong level or `done` missing. This is visible within a few cycles of the synchronised `ack_n` change that should have moved it. A bit counter that is wrong would let extra clock edges corrupt `rx_byte`, or let the bits on `sdout` drift. That shows up at the first done after the ninth edge, or as soon as the peer samples a misplaced bit. A direction latch that is wrong would leave `sdout` away from 1 after a receive is accepted, or let `rx_byte` change at the end of a send. In both cases the error is observable by the following done.

// File: rtl/pmbl_pkg.sv
`timescale 1ns/1ps
package pmbl_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_ASK  = 2'd1,
    LK_REL  = 2'd2,
    LK_FIN  = 2'd3
  } link_st_e;
endpackage

// File: rtl/pmbl_sync.sv
`timescale 1ns/1ps
module pmbl_sync #(
  parameter int         WIDTH   = 1,
  parameter int         STAGES  = 2,
  parameter logic [0:0] RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pmbl_shifter.sv
`timescale 1ns/1ps
module pmbl_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run,
  input  logic              sclk_s,
  input  logic              bit_in,
  output logic [DATA_W-1:0] sr_q
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             sclk_d;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             rise;

  assign full = (cnt_q == CNT_W'(DATA_W));
  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (load) begin
        sr_q  <= load_val;
        cnt_q <= '0;
      end else if (run && rise && !full) begin
        sr_q  <= {sr_q[DATA_W-2:0], bit_in};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmbl_fsm.sv
`timescale 1ns/1ps
module pmbl_fsm
  import pmbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_fire,
  input  logic ack_s,
  output logic idle,
  output logic req_n,
  output logic capture,
  output logic fin
);
  link_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_IDLE: if (start_fire) st_d = LK_ASK;
      LK_ASK:  if (!ack_s)     st_d = LK_REL;
      LK_REL:  if (ack_s)      st_d = LK_FIN;
      LK_FIN:                  st_d = LK_IDLE;
      default:                 st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign idle    = (st_q == LK_IDLE);
  assign req_n   = (st_q != LK_ASK);
  assign capture = (st_q == LK_REL) && ack_s;
  assign fin     = (st_q == LK_FIN);
endmodule

// File: rtl/pm_byte_link.sv
`timescale 1ns/1ps
module pm_byte_link #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_dir,
  input  logic [DATA_W-1:0] start_byte,
  output logic              req_n,
  input  logic              ack_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              sdout,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              busy
);
  logic              ack_s;
  logic [1:0]        ser_s;
  logic              idle;
  logic              capture;
  logic              start_fire;
  logic              mode_rx_q;
  logic [DATA_W-1:0] sr_q;

  pmbl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_s)
  );

  pmbl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ser_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, sdin}), .q(ser_s)
  );

  assign start_fire = start_valid & idle;

  pmbl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_fire(start_fire), .ack_s(ack_s),
    .idle(idle), .req_n(req_n), .capture(capture), .fin(done)
  );

  pmbl_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(start_fire),
    .load_val(start_dir ? {DATA_W{1'b0}} : start_byte),
    .run(!idle),
    .sclk_s(ser_s[1]),
    .bit_in(ser_s[0]),
    .sr_q(sr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_rx_q <= 1'b1;
      rx_byte   <= '0;
    end else begin
      if (start_fire) mode_rx_q <= start_dir;
      if (capture && mode_rx_q) rx_byte <= sr_q;
    end
  end

  assign start_ready = idle;
  assign busy        = !idle;
  assign sdout       = (busy && !mode_rx_q) ? sr_q[DATA_W-1] : 1'b1;
endmodule

// File: rtl/pmbl_checker.sv
`timescale 1ns/1ps
module pmbl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              busy,
  input logic              done,
  input logic              req_n,
  input logic              sdout,
  input logic [DATA_W-1:0] rx_byte
);
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid));

  assert_req_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_n);

  assert_req_high_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_n);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_sdout_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdout);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_byte));
endmodule

bind pm_byte_link pmbl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .busy(busy),
  .done(done), .req_n(req_n), .sdout(sdout), .rx_byte(rx_byte)
);

// File: tb/pm_byte_link_bench.sv
`timescale 1ns/1ps
module pm_byte_link_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic       start_ready;
  logic       start_dir = 1'b0;
  logic [7:0] start_byte = 8'h00;
  logic       req_n;
  logic       ack_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdin = 1'b0;
  logic       sdout;
  logic [7:0] rx_byte;
  logic       done;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int done_run = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pm_byte_link u_pm_byte_link (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_dir(start_dir), .start_byte(start_byte), .req_n(req_n), .ack_n(ack_n),
    .sclk(sclk), .sdin(sdin), .sdout(sdout), .rx_byte(rx_byte), .done(done), .busy(busy)
  );

  // {dir, byte offered by host, byte driven by peer}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h00}, {1'b1, 8'h00, 8'h3C}, {1'b0, 8'h81, 8'hFF},
    {1'b1, 8'hFF, 8'hC3}, {1'b0, 8'h00, 8'h55}, {1'b1, 8'h5A, 8'h01}
  };

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      done_run++;
      if (done_run > 1) begin
        errors++;
        $display("FAIL R5 done width: actual %0d cycles expected 1", done_run);
      end
    end else done_run = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic dir, input logic [7:0] b);
    @(negedge clk);
    start_dir = dir; start_byte = b; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic wait_req(input logic lvl, input string req);
    int n = 0;
    while (req_n !== lvl && n < 200) begin @(negedge clk); n++; end
    chk(req_n === lvl, req, {31'b0, req_n}, {31'b0, lvl});
  endtask

  // Peer side: clocks pulses, then closes the handshake holding ack low for ack_hold cycles
  task automatic peer(input logic [7:0] pbyte, input int pulses, input int ack_hold, output logic [7:0] seen);
    bit bad_done = 1'b0;
    bit bad_busy = 1'b0;
    seen = 8'h00;
    wait_req(1'b0, "R4 req low after start");
    for (int i = 0; i < pulses; i++) begin
      sdin = (i < 8) ? pbyte[7-i] : 1'b1;
      repeat (5) @(negedge clk);
      if (i < 8) seen[7-i] = sdout;
      sclk = 1'b1;
      repeat (5) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(req_n === 1'b0, "R4 req held until ack", {31'b0, req_n}, 32'd0);
    ack_n = 1'b0;
    wait_req(1'b1, "R4 req released after ack");
    for (int i = 0; i < ack_hold; i++) begin
      @(negedge clk);
      if (done) bad_done = 1'b1;
      if (!busy) bad_busy = 1'b1;
    end
    chk(!bad_done && !bad_busy, "R5 no done while ack low", {30'b0, bad_done, bad_busy}, 32'd0);
    ack_n = 1'b1;
  endtask

  task automatic finish_xfer(input int base_done);
    int n = 0;
    while (done_cnt == base_done && n < 50) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == base_done + 1, "R5 one done per transfer", done_cnt - base_done, 32'd1);
    chk(!busy && start_ready, "R2 idle after done", {30'b0, busy, start_ready}, 32'd1);
  endtask

  initial begin
    logic [7:0] seen;
    logic [7:0] exp_rx;
    int base;

    repeat (4) @(negedge clk);
    chk(req_n === 1'b1 && sdout === 1'b1 && busy === 1'b0 && done === 1'b0 && start_ready === 1'b1,
        "R1 reset outputs", {27'b0, req_n, sdout, busy, done, start_ready}, 32'b11001);
    chk(rx_byte === 8'h00, "R1 reset rx_byte", {24'b0, rx_byte}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {30'b0, req_n, busy}, 32'b10);

    exp_rx = 8'h00;
    for (int v = 0; v < 6; v++) begin
      base = done_cnt;
      issue(VEC[v][16], VEC[v][15:8]);
      chk(busy === 1'b1 && start_ready === 1'b0, "R2 busy after accept", {30'b0, busy, start_ready}, 32'b10);
      if (VEC[v][16]) chk(sdout === 1'b1, "R6 sdout high in receive", {31'b0, sdout}, 32'd1);
      peer(VEC[v][7:0], 8, 4 + v, seen);
      finish_xfer(base);
      if (VEC[v][16]) begin
        exp_rx = VEC[v][7:0];
        chk(rx_byte === exp_rx, "R7 received byte", {24'b0, rx_byte}, {24'b0, exp_rx});
      end else begin
        chk(seen === VEC[v][15:8], "R6 sent byte MSB first", {24'b0, seen}, {24'b0, VEC[v][15:8]});
        chk(rx_byte === exp_rx, "R9 rx_byte held over send", {24'b0, rx_byte}, {24'b0, exp_rx});
      end
      chk(sdout === 1'b1, "R6 sdout high when idle", {31'b0, sdout}, 32'd1);
    end

    // R3: start offered mid-transfer is ignored
    base = done_cnt;
    issue(1'b1, 8'h00);
    wait_req(1'b0, "R4 req low R3 case");
    @(negedge clk);
    start_dir = 1'b0; start_byte = 8'hFF; start_valid = 1'b1;
    @(negedge clk);
    chk(start_ready === 1'b0, "R3 not ready while busy", {31'b0, start_ready}, 32'd0);
    @(negedge clk);
    start_valid = 1'b0;
    chk(sdout === 1'b1, "R3 busy start left sdout", {31'b0, sdout}, 32'd1);
    peer(8'h6E, 8, 3, seen);
    finish_xfer(base);
    chk(rx_byte === 8'h6E, "R3 result unchanged", {24'b0, rx_byte}, 32'h6E);
    begin
      bit extra = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!req_n || busy) extra = 1'b1;
      end
      chk(!extra, "R3 no second transfer", {31'b0, extra}, 32'd0);
    end

    // R8: surplus clock edges ignored in receive and send
    base = done_cnt;
    issue(1'b1, 8'h00);
    peer(8'h96, 11, 2, seen);
    finish_xfer(base);
    chk(rx_byte === 8'h96, "R8 receive extra edges", {24'b0, rx_byte}, 32'h96);
    base = done_cnt;
    issue(1'b0, 8'h4B);
    peer(8'h00, 10, 2, seen);
    finish_xfer(base);
    chk(seen === 8'h4B, "R8 send extra edges", {24'b0, seen}, 32'h4B);
    chk(rx_byte === 8'h96, "R9 rx_byte after send", {24'b0, rx_byte}, 32'h96);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule